// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns a stream of relative pointer motion and button activity into five-byte reports for a bus-style serial mouse link. Motion arrives as signed X and Y deltas with a valid strobe; buttons arrive as per-button press and release strobes. The block sums motion into signed, saturating accumulators and keeps the current button state. When a sync strobe arrives and there is something to report, it writes one report into an internal byte FIFO.

Each report has five bytes. The first is a start byte that carries the button state with pressed buttons read as zero. The next two carry X and Y motion, each limited to ±127. Any motion beyond that limit stays in the accumulator and goes out in later reports. The last two bytes are always zero. A downstream serializer drains the FIFO through a valid/ready byte interface. A one-cycle pulse marks each moment the FIFO goes from empty to holding data.

Top module: `mouse_pkt_encoder`

## Requirements
- R1: The start byte is 0x87 XOR the held-button mask, where left = bit 2 (0x4), middle = bit 1 (0x2) and right = bit 0 (0x1). A held button reads as 0 and a released one as 1. A release strobe clears a button's held state and a press strobe sets it.
- R2: Each valid motion cycle adds mv_dx to the X accumulator and subtracts mv_dy from the Y accumulator. The second byte reports X and the third reports Y.
- R3: The X and Y bytes are the accumulator clamped to -127..+127 and sent as 8-bit two's complement. The clamped amount is subtracted from the accumulator, so the rest is reported by later packets.
- R4: The fourth and fifth bytes of every packet are 0x00.
- R5: Any press or release strobe sets an event flag, and writing a start byte clears it. A sync produces no packet when both accumulators are zero and the flag is clear.
- R6: Each accumulator is a 16-bit signed value that saturates at +32767 and -32768 instead of wrapping.
- R7: The FIFO holds 16 bytes and delivers them in order. A byte offered while it holds 16 is dropped. While out_valid is high and out_ready is low, out_data holds steady.
- R8: rx_avail is high for exactly one cycle, in the first cycle out_valid is high after the FIFO was empty.
- R9: The start byte enters the FIFO at the clock edge that samples the sync. The other four bytes follow on the next four consecutive edges.
- R10: A sync that arrives while a packet is being written is held. It is serviced once that packet is complete.
- R11: Reset clears the FIFO, both accumulators, the button state, the event flag and any held sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mv_valid | input | 1 | Motion deltas valid this cycle |
| mv_dx | input | 8 | Signed X delta |
| mv_dy | input | 8 | Signed Y delta |
| btn_press | input | 3 | Press strobes, bit 2 left, bit 1 middle, bit 0 right |
| btn_release | input | 3 | Release strobes, same bit order |
| sync_req | input | 1 | Request a packet |
| out_valid | output | 1 | FIFO holds a byte |
| out_data | output | 8 | Byte at the FIFO head |
| out_ready | input | 1 | Consumer takes the head byte this cycle |
| rx_avail | output | 1 | One-cycle pulse when the FIFO leaves empty |

## Verification
The hardest state to reach from the ports is accumulator saturation. The input deltas are limited to 8 bits and every packet drains up to 127, so reaching the 16-bit limit takes hundreds of motion cycles with no sync in between. The stimulus drives 300 cycles of +127 and then issues syncs until no packet appears. The sum of the reported X bytes must then equal exactly 32767. A sync held during emission is reached by pulsing a second sync two cycles after the first, while the packer is still busy. FIFO overflow is reached by holding out_ready low across four packets.

// File: rtl/mpe_pkg.sv
// Package: shared types and constants for the serial mouse packet encoder.
// Assumes a three-button mouse and an 8-bit byte stream.
package mpe_pkg;
    localparam int          NUM_BTN    = 3;
    localparam logic [7:0]  START_BASE = 8'h87;

    typedef enum logic [2:0] {
        PK_IDLE,
        PK_XB,
        PK_YB,
        PK_Z1,
        PK_Z2
    } pk_state_e;
endpackage

// File: rtl/mpe_accum.sv
// Motion and button state keeper.
// Sums signed X deltas and negated Y deltas into saturating accumulators,
// subtracts the amounts the packer reports, tracks held buttons and an
// event flag. Assumes take_x/take_y are zero when no byte is reported.
module mpe_accum #(
    parameter int DELTA_W = 8,
    parameter int ACC_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mv_valid,
    input  logic signed [DELTA_W-1:0]  mv_dx,
    input  logic signed [DELTA_W-1:0]  mv_dy,
    input  logic [mpe_pkg::NUM_BTN-1:0] btn_press,
    input  logic [mpe_pkg::NUM_BTN-1:0] btn_release,
    input  logic signed [7:0]          take_x,
    input  logic signed [7:0]          take_y,
    input  logic                       evt_clr,
    output logic signed [ACC_W-1:0]    acc_x,
    output logic signed [ACC_W-1:0]    acc_y,
    output logic [mpe_pkg::NUM_BTN-1:0] btn_held,
    output logic                       evt
);
    localparam int SUM_W = ACC_W + 2;
    localparam logic signed [SUM_W-1:0] MAX_S =
        $signed({{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}});
    localparam logic signed [SUM_W-1:0] MIN_S = -MAX_S - 1;
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};

    logic signed [SUM_W-1:0] dx_ext, dy_ext, sum_x, sum_y;
    logic                    any_btn;

    function automatic logic signed [ACC_W-1:0] sat(input logic signed [SUM_W-1:0] v);
        if (v > MAX_S)      return MAX_S[ACC_W-1:0];
        else if (v < MIN_S) return MIN_S[ACC_W-1:0];
        else                return v[ACC_W-1:0];
    endfunction

    // Form the next accumulator values at full width before saturation.
    always_comb begin
        dx_ext = mv_valid ? SUM_W'(mv_dx) : {SUM_W{1'b0}};
        dy_ext = mv_valid ? SUM_W'(mv_dy) : {SUM_W{1'b0}};
        sum_x  = SUM_W'(acc_x) + dx_ext - SUM_W'(take_x);
        sum_y  = SUM_W'(acc_y) - dy_ext - SUM_W'(take_y);
        any_btn = |(btn_press | btn_release);
    end

    // Register accumulators, held buttons and the event flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_x    <= '0;
            acc_y    <= '0;
            btn_held <= '0;
            evt      <= 1'b0;
        end else begin
            acc_x    <= sat(sum_x);
            acc_y    <= sat(sum_y);
            btn_held <= (btn_held & ~btn_release) | btn_press;
            evt      <= (evt & ~evt_clr) | any_btn;
        end
    end

    assert_take_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_x != 8'h80) && (take_y != 8'h80));

    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid && !mv_dx[DELTA_W-1] && take_x == 8'sd0 && acc_x == ACC_MAX)
        |=> acc_x == ACC_MAX);

    assert_evt_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(btn_press | btn_release)) |=> evt);
endmodule

// File: rtl/mpe_packer.sv
// Packet sequencer.
// On sync (or a held sync) with pending motion or button events, writes the
// start byte, clamped X, clamped Y and two zero bytes on five consecutive
// cycles, and reports the clamped amounts back to the accumulators.
// Assumes the FIFO accepts or drops each byte in the cycle it is offered.
module mpe_packer #(
    parameter int ACC_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sync_req,
    input  logic signed [ACC_W-1:0]     acc_x,
    input  logic signed [ACC_W-1:0]     acc_y,
    input  logic [mpe_pkg::NUM_BTN-1:0] btn_held,
    input  logic                        evt,
    output logic                        push,
    output logic [7:0]                  push_data,
    output logic signed [7:0]           take_x,
    output logic signed [7:0]           take_y,
    output logic                        evt_clr
);
    import mpe_pkg::*;

    localparam logic signed [ACC_W-1:0] LIM  = ACC_W'(127);
    localparam logic signed [ACC_W-1:0] NLIM = -LIM;

    pk_state_e        state_q, state_d;
    logic             pend_q;
    logic             has_work, go;
    logic signed [7:0] clamp_x, clamp_y;

    function automatic logic signed [7:0] clamp7(input logic signed [ACC_W-1:0] a);
        if (a > LIM)       return 8'sd127;
        else if (a < NLIM) return -8'sd127;
        else               return a[7:0];
    endfunction

    // Decide whether a packet starts and compute the clamped motion bytes.
    always_comb begin
        has_work = (acc_x != '0) || (acc_y != '0) || evt;
        go       = (state_q == PK_IDLE) && (sync_req || pend_q) && has_work;
        clamp_x  = clamp7(acc_x);
        clamp_y  = clamp7(acc_y);
    end

    // Drive the byte, the take amounts and the next state for each step.
    always_comb begin
        push      = 1'b0;
        push_data = 8'h00;
        take_x    = 8'sd0;
        take_y    = 8'sd0;
        evt_clr   = 1'b0;
        state_d   = state_q;
        case (state_q)
            PK_IDLE: if (go) begin
                push      = 1'b1;
                push_data = START_BASE ^ 8'(btn_held);
                evt_clr   = 1'b1;
                state_d   = PK_XB;
            end
            PK_XB: begin
                push      = 1'b1;
                push_data = clamp_x;
                take_x    = clamp_x;
                state_d   = PK_YB;
            end
            PK_YB: begin
                push      = 1'b1;
                push_data = clamp_y;
                take_y    = clamp_y;
                state_d   = PK_Z1;
            end
            PK_Z1: begin
                push    = 1'b1;
                state_d = PK_Z2;
            end
            PK_Z2: begin
                push    = 1'b1;
                state_d = PK_IDLE;
            end
            default: state_d = PK_IDLE;
        endcase
    end

    // Advance the sequencer and hold a sync seen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PK_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= (state_q == PK_IDLE) ? 1'b0 : (pend_q | sync_req);
        end
    end

    assert_busy_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PK_IDLE) |-> push);

    assert_tail_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PK_Z1 || state_q == PK_Z2) |-> (push_data == 8'h00));

    assert_no_empty_pkt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && state_q == PK_IDLE) |-> (acc_x != '0 || acc_y != '0 || evt));

    assert_sync_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PK_IDLE && sync_req) |=> pend_q);
endmodule

// File: rtl/mpe_byte_fifo.sv
// Byte FIFO with drop-on-full.
// Accepts a byte when it holds fewer than DEPTH entries, otherwise drops it.
// Raises a one-cycle availability pulse when it leaves the empty state.
module mpe_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    input  logic             out_ready,
    output logic             rx_avail
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             push_ok, pop, avail_q;

    // Qualify the write and read handshakes.
    always_comb begin
        push_ok = push && (count != FULL_CNT);
        pop     = (count != '0) && out_ready;
    end

    // Store accepted bytes.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_data;
    end

    // Move pointers, track occupancy and form the availability pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            avail_q <= 1'b0;
        end else begin
            if (push_ok) wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
            if (pop)     rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
            case ({push_ok, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            avail_q <= push_ok && (count == '0);
        end
    end

    assign out_valid = (count != '0);
    assign out_data  = mem[rptr];
    assign rx_avail  = avail_q;

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    assert_stall_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_avail_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail |=> !rx_avail);

    assert_avail_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail |-> out_valid);
endmodule

// File: rtl/mouse_pkt_encoder.sv
// Top of the serial mouse packet encoder.
// Connects the accumulator, the packet sequencer and the output byte FIFO.
// Assumes all inputs are synchronous to clk.
module mouse_pkt_encoder #(
    parameter int DELTA_W    = 8,
    parameter int ACC_W      = 16,
    parameter int FIFO_DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mv_valid,
    input  logic [DELTA_W-1:0] mv_dx,
    input  logic [DELTA_W-1:0] mv_dy,
    input  logic [2:0]         btn_press,
    input  logic [2:0]         btn_release,
    input  logic               sync_req,
    output logic               out_valid,
    output logic [7:0]         out_data,
    input  logic               out_ready,
    output logic               rx_avail
);
    logic signed [ACC_W-1:0] acc_x, acc_y;
    logic [2:0]              btn_held;
    logic                    evt, evt_clr, push;
    logic [7:0]              push_data;
    logic signed [7:0]       take_x, take_y;

    mpe_accum #(.DELTA_W(DELTA_W), .ACC_W(ACC_W)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .mv_valid   (mv_valid),
        .mv_dx      ($signed(mv_dx)),
        .mv_dy      ($signed(mv_dy)),
        .btn_press  (btn_press),
        .btn_release(btn_release),
        .take_x     (take_x),
        .take_y     (take_y),
        .evt_clr    (evt_clr),
        .acc_x      (acc_x),
        .acc_y      (acc_y),
        .btn_held   (btn_held),
        .evt        (evt)
    );

    mpe_packer #(.ACC_W(ACC_W)) u_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_req (sync_req),
        .acc_x    (acc_x),
        .acc_y    (acc_y),
        .btn_held (btn_held),
        .evt      (evt),
        .push     (push),
        .push_data(push_data),
        .take_x   (take_x),
        .take_y   (take_y),
        .evt_clr  (evt_clr)
    );

    mpe_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_data(push_data),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_ready(out_ready),
        .rx_avail (rx_avail)
    );
endmodule

// File: tb/mouse_pkt_encoder_tb.sv
module mouse_pkt_encoder_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] dx;
        logic [7:0] dy;
        logic [2:0] press;
        logic [2:0] rel;
        logic       has;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
    } vec_t;

    // Vectors run in order; accumulator and button state carry between them.
    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'h05, 8'h03, 3'b000, 3'b000, 1'b1, 8'h87, 8'h05, 8'hFD}, // R2 Y negated
        '{8'h00, 8'h00, 3'b100, 3'b000, 1'b1, 8'h83, 8'h00, 8'h00}, // R1 left held
        '{8'h00, 8'h00, 3'b000, 3'b000, 1'b0, 8'h00, 8'h00, 8'h00}, // R5 nothing
        '{8'hF6, 8'h00, 3'b000, 3'b100, 1'b1, 8'h87, 8'hF6, 8'h00}, // R1 release
        '{8'h7F, 8'h80, 3'b000, 3'b000, 1'b1, 8'h87, 8'h7F, 8'h7F}, // R3 clamp Y
        '{8'h80, 8'h00, 3'b011, 3'b000, 1'b1, 8'h84, 8'h81, 8'h01}, // R3 carry Y
        '{8'h00, 8'h00, 3'b000, 3'b000, 1'b1, 8'h84, 8'hFF, 8'h00}, // R3 carry X
        '{8'h00, 8'h00, 3'b000, 3'b011, 1'b1, 8'h87, 8'h00, 8'h00}  // R5 release evt
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mv_valid = 1'b0;
    logic [7:0] mv_dx = '0, mv_dy = '0;
    logic [2:0] btn_press = '0, btn_release = '0;
    logic       sync_req = 1'b0;
    logic       out_ready = 1'b1;
    logic       out_valid, rx_avail;
    logic [7:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    logic [7:0] cap_q [$];
    int         cyc_q [$];

    mouse_pkt_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .mv_valid(mv_valid), .mv_dx(mv_dx),
        .mv_dy(mv_dy), .btn_press(btn_press), .btn_release(btn_release),
        .sync_req(sync_req), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .rx_avail(rx_avail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Record every byte the consumer takes (handshake at the coming edge).
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            cap_q.push_back(out_data);
            cyc_q.push_back(cyc);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic motion(input logic [7:0] dx, input logic [7:0] dy,
                          input logic [2:0] pr, input logic [2:0] rl);
        mv_valid = 1'b1; mv_dx = dx; mv_dy = dy; btn_press = pr; btn_release = rl;
        @(negedge clk);
        mv_valid = 1'b0; mv_dx = '0; mv_dy = '0; btn_press = '0; btn_release = '0;
    endtask

    task automatic pulse_sync();
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        finish_run();
    end

    initial begin
        ticks(3);
        // R11: reset state
        check(out_valid == 1'b0, "R11 out_valid after reset", out_valid, 0);
        check(rx_avail == 1'b0, "R11 rx_avail after reset", rx_avail, 0);
        rst_n = 1'b1;
        ticks(2);
        cap_q.delete(); cyc_q.delete();
        pulse_sync();
        ticks(8);
        check(cap_q.size() == 0, "R11 R5 no packet from reset state", cap_q.size(), 0);

        // Table of vectors with out_ready held high.
        for (int v = 0; v < NVEC; v++) begin
            cap_q.delete(); cyc_q.delete();
            motion(VECS[v].dx, VECS[v].dy, VECS[v].press, VECS[v].rel);
            pulse_sync();
            ticks(8);
            if (!VECS[v].has) begin
                check(cap_q.size() == 0, "R5 empty sync", cap_q.size(), 0);
            end else begin
                check(cap_q.size() == 5, "R9 packet length", cap_q.size(), 5);
                if (cap_q.size() == 5) begin
                    check(cap_q[0] == VECS[v].b0, "R1 start byte", cap_q[0], VECS[v].b0);
                    check(cap_q[1] == VECS[v].b1, "R2 R3 X byte", cap_q[1], VECS[v].b1);
                    check(cap_q[2] == VECS[v].b2, "R2 R3 Y byte", cap_q[2], VECS[v].b2);
                    check(cap_q[3] == 8'h00 && cap_q[4] == 8'h00, "R4 tail bytes",
                          {cap_q[3], cap_q[4]}, 0);
                    check(cyc_q[4] - cyc_q[0] == 4, "R9 consecutive bytes",
                          cyc_q[4] - cyc_q[0], 4);
                end
            end
        end

        // R10: second sync while the first packet is being written.
        cap_q.delete(); cyc_q.delete();
        motion(8'd100, 8'd0, 3'b000, 3'b000);
        motion(8'd100, 8'd0, 3'b000, 3'b000);
        pulse_sync();
        ticks(1);
        pulse_sync();
        ticks(14);
        check(cap_q.size() == 10, "R10 held sync gives two packets", cap_q.size(), 10);
        if (cap_q.size() == 10) begin
            check(cap_q[1] == 8'h7F, "R3 first X clamped", cap_q[1], 8'h7F);
            check(cap_q[5] == 8'h87 && cap_q[6] == 8'h49, "R10 R3 residual packet",
                  {cap_q[5], cap_q[6]}, 16'h8749);
        end

        // R7 R8: overflow with consumer stalled.
        out_ready = 1'b0;
        for (int p = 0; p < 4; p++) begin
            motion(8'd1, 8'd0, 3'b000, 3'b000);
            pulse_sync();
            if (p == 0) begin
                check(rx_avail == 1'b1 && out_valid == 1'b1, "R8 avail pulse high",
                      {rx_avail, out_valid}, 3);
                ticks(1);
                check(rx_avail == 1'b0 && out_valid == 1'b1, "R8 avail pulse one cycle",
                      {rx_avail, out_valid}, 1);
                ticks(5);
            end else begin
                ticks(6);
            end
        end
        cap_q.delete(); cyc_q.delete();
        out_ready = 1'b1;
        ticks(20);
        out_ready = 1'b0;
        check(cap_q.size() == 16, "R7 only depth bytes kept", cap_q.size(), 16);
        if (cap_q.size() == 16) begin
            check(cap_q[1] == 8'h01 && cap_q[14] == 8'h00, "R7 order kept",
                  {cap_q[1], cap_q[14]}, 16'h0100);
            check(cap_q[15] == 8'h87, "R7 last kept byte is start of 4th packet",
                  cap_q[15], 8'h87);
        end
        check(out_valid == 1'b0, "R7 FIFO empty after drain", out_valid, 0);
        out_ready = 1'b1;

        // R11: reset mid-run discards motion and buttons.
        motion(8'd9, 8'd0, 3'b100, 3'b000);
        rst_n = 1'b0;
        ticks(2);
        rst_n = 1'b1;
        ticks(1);
        cap_q.delete(); cyc_q.delete();
        motion(8'd2, 8'd0, 3'b000, 3'b000);
        pulse_sync();
        ticks(8);
        check(cap_q.size() == 5, "R11 packet after reset", cap_q.size(), 5);
        if (cap_q.size() == 5)
            check(cap_q[0] == 8'h87 && cap_q[1] == 8'h02, "R11 state cleared",
                  {cap_q[0], cap_q[1]}, 16'h8702);

        // R6: drive X into saturation, then drain it packet by packet.
        for (int i = 0; i < 300; i++) motion(8'd127, 8'd0, 3'b000, 3'b000);
        begin
            int npkt;
            int sum;
            npkt = 0;
            sum = 0;
            for (int i = 0; i < 300; i++) begin
                cap_q.delete(); cyc_q.delete();
                pulse_sync();
                ticks(8);
                if (cap_q.size() == 0) break;
                npkt++;
                if (cap_q.size() >= 2) sum += int'($signed(cap_q[1]));
            end
            check(sum == 32767, "R6 saturated total", sum, 32767);
            check(npkt == 259, "R6 packet count", npkt, 259);
        end

        finish_run();
    end
endmodule